// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a virtual page number into a physical address by reading page table entries from memory. It starts from a table base, reads one 64-bit entry per level, and moves from the top directory level through two more directory levels down to the final page table level. It needs one handshake on the memory request port for each level it reads. It keeps only one read outstanding at a time and holds a request stable while the memory side applies backpressure.

Any directory entry can end the walk early when it carries the leaf marker. The translation then covers a large page. The size of that page comes from a fragment field in the entry and is capped by the span that the level covers. Each response ends in one of three ways: a completed translation, a fault tagged with the access mode and the entry's valid bit, or a request for the next level. A configuration error strobe flags directory entries whose block-fragment field is not zero.

Top module: `pt_walker`

## Requirements
- R1: The first read address is `{base[47:6], 6'b0} + 8 * vpn[35:27]`, taken modulo 2^48. The first read is cacheable, so `mem_req_uncached` is 0.
- R2: After a non-ending directory entry E, the next read address is `{E[47:6], 6'b0} + 8 * idx`, taken modulo 2^48. Here idx is vpn[26:18] after the top level, vpn[17:9] after the middle level and vpn[8:0] after the lowest directory level.
- R3: A read issued after entry E has `mem_req_uncached` equal to the inverse of E bit 2, the cacheable bit.
- R4: A valid directory entry with bit 54 set, the leaf marker, ends the walk. It reports log2 page size = 12 + min(span, E[11:7]), where span is 27, 18 and 9 for the top, middle and lowest directory levels. An entry at the last level always ends the walk with a log2 size of 12.
- R5: On success, `done_entry` equals the ending entry. With L the log2 size, `done_paddr` is `({E[51:12],12'b0} + ({vpn,12'b0} mod 2^L))` mod 2^48, and `done_vbase` is `{vpn,12'b0}` with its low L bits cleared.
- R6: An entry with bit 0, the valid bit, clear ends the walk with a fault. `fault_present` is 0 and `fault_mode` equals the request mode.
- R7: An entry with bit 4, the no-execute bit, set causes a fault with `fault_present`=1 when the mode is execute (2'b10). For read (2'b00) and write (2'b01) the bit has no effect on the walk.
- R8: `cfg_err` pulses together with the result of a directory-level response whose bits [63:59] are not zero. The walk otherwise proceeds as if the field were zero. At the last level those bits are ignored.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with the same address and uncached flag. No new request is issued while a response is pending.
- R10: `req_ready` is high only when the walker is idle. `done_valid` and `fault_valid` are one-cycle pulses, never high together, and the walker is idle when either one is high.
- R11: After reset, `req_ready` is 1 and `mem_req_valid`, `done_valid`, `fault_valid` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_base | input | 48 | Page table base address |
| req_vpn | input | 36 | Virtual page number |
| req_mode | input | 2 | Access mode: 0 read, 1 write, 2 execute |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 48 | Byte address of the 8-byte entry |
| mem_req_uncached | output | 1 | Read must bypass caches |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read, little-endian word |
| done_valid | output | 1 | Translation complete pulse |
| done_entry | output | 64 | Ending entry |
| done_log2size | output | 6 | log2 of page size |
| done_paddr | output | 48 | Physical address |
| done_vbase | output | 48 | Page-aligned virtual base |
| fault_valid | output | 1 | Fault pulse |
| fault_present | output | 1 | Valid bit of faulting entry |
| fault_mode | output | 2 | Access mode of faulting walk |
| cfg_err | output | 1 | Illegal block-fragment field seen |

## Verification
A wrong level counter shows up at the port on the very next read. That read would use the wrong slice of the virtual page number, or the walk would end or continue one read too early. The bench compares every request address and the uncached flag as soon as the request appears. A corrupted request under backpressure is caught within one stalled cycle. A wrong leaf, fault or size decode appears in the same cycle as the result pulse, one clock after the response.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int PA_W     = 48;
  localparam int VPN_W    = 36;
  localparam int ENT_W    = 64;
  localparam int PG_SHIFT = 12;
  localparam int IDX_W    = 9;
  localparam int FRAG_W   = 5;
  localparam int LOG2_W   = 6;
  localparam int N_LEVELS = 4;
  localparam int VA_W     = VPN_W + PG_SHIFT;
  localparam int PPN_W    = ENT_W - 12 - PG_SHIFT;   // 40-bit ppn at [51:12]

  localparam int B_VALID  = 0;
  localparam int B_CACHE  = 2;
  localparam int B_NOEXEC = 4;
  localparam int B_LEAF   = 54;
  localparam int FRAG_LSB = 7;
  localparam int PPN_LSB  = 12;
  localparam int BFS_LSB  = 59;

  localparam logic [1:0] MD_EXEC = 2'b10;

  typedef enum logic [1:0] {
    LV_DIR2 = 2'd0,
    LV_DIR1 = 2'd1,
    LV_DIR0 = 2'd2,
    LV_LEAF = 2'd3
  } level_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_st_e;

  // Levels below the given one, in index bits.
  function automatic int level_span(level_e lv);
    return IDX_W * (N_LEVELS - 1 - int'(lv));
  endfunction

  function automatic logic [IDX_W-1:0] level_index(logic [VPN_W-1:0] vpn, level_e lv);
    logic [VPN_W-1:0] sh;
    sh = vpn >> level_span(lv);
    return sh[IDX_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] table_addr(logic [ENT_W-1:0] ptr, logic [IDX_W-1:0] idx);
    logic [ENT_W-1:0] t;
    t = ((ptr >> 6) << 3) + ENT_W'(idx);
    t = t << 3;
    return t[PA_W-1:0];
  endfunction

  function automatic logic [LOG2_W-1:0] page_log2(level_e lv, logic [FRAG_W-1:0] frag);
    int f;
    f = int'(frag);
    if (f > level_span(lv)) f = level_span(lv);
    return LOG2_W'(PG_SHIFT + f);
  endfunction
endpackage

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
  import pt_walker_pkg::*;
(
  input  logic [ENT_W-1:0]  entry,
  input  level_e            lvl,
  input  logic [1:0]        mode,
  output logic              is_leaf,
  output logic              is_fault,
  output logic              present,
  output logic              bad_frag,
  output logic              uncached_next,
  output logic [LOG2_W-1:0] log2sz
);
  logic nx_hit;

  always_comb begin
    present       = entry[B_VALID];
    nx_hit        = entry[B_NOEXEC] && (mode == MD_EXEC);
    is_fault      = !present || nx_hit;
    is_leaf       = (lvl == LV_LEAF) || entry[B_LEAF];
    bad_frag      = (lvl != LV_LEAF) && (entry[ENT_W-1:BFS_LSB] != '0);
    uncached_next = !entry[B_CACHE];
    log2sz        = page_log2(lvl, entry[FRAG_LSB +: FRAG_W]);
  end
endmodule

// File: rtl/pt_result_calc.sv
module pt_result_calc
  import pt_walker_pkg::*;
(
  input  logic [ENT_W-1:0]  entry,
  input  logic [LOG2_W-1:0] log2sz,
  input  logic [VPN_W-1:0]  vpn,
  output logic [PA_W-1:0]   paddr,
  output logic [PA_W-1:0]   vbase
);
  logic [VA_W-1:0]  va;
  logic [VA_W-1:0]  off_mask;
  logic [PPN_W+PG_SHIFT-1:0] frame;

  always_comb begin
    va       = {vpn, {PG_SHIFT{1'b0}}};
    off_mask = (VA_W'(1) << log2sz) - VA_W'(1);
    frame    = {entry[PPN_LSB +: PPN_W], {PG_SHIFT{1'b0}}};
    paddr    = frame[PA_W-1:0] + PA_W'(va & off_mask);
    vbase    = PA_W'(va & ~off_mask);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PA_W-1:0]   req_base,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [1:0]        req_mode,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  output logic              mem_req_uncached,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  output logic              done_valid,
  output logic [ENT_W-1:0]  done_entry,
  output logic [LOG2_W-1:0] done_log2size,
  output logic [PA_W-1:0]   done_paddr,
  output logic [PA_W-1:0]   done_vbase,
  output logic              fault_valid,
  output logic              fault_present,
  output logic [1:0]        fault_mode,
  output logic              cfg_err
);
  walk_st_e          st_q;
  level_e            lvl_q;
  level_e            lvl_nxt;
  logic [VPN_W-1:0]  vpn_q;
  logic [1:0]        mode_q;
  logic [PA_W-1:0]   addr_q;
  logic              unc_q;

  logic              d_leaf, d_fault, d_present, d_bad, d_unc;
  logic [LOG2_W-1:0] d_log2;
  logic [PA_W-1:0]   r_paddr, r_vbase;

  // Named events for the assertions.
  logic walk_waiting, rsp_taken, walk_end, walk_accept;

  assign lvl_nxt      = level_e'(lvl_q + 2'd1);
  assign walk_waiting = (st_q == ST_WAIT);
  assign rsp_taken    = walk_waiting && mem_rsp_valid;
  assign walk_end     = rsp_taken && (d_leaf || d_fault);
  assign walk_accept  = req_valid && req_ready;

  assign req_ready        = (st_q == ST_IDLE);
  assign mem_req_valid    = (st_q == ST_ISSUE);
  assign mem_req_addr     = addr_q;
  assign mem_req_uncached = unc_q;

  pt_entry_decode u_dec (
    .entry         (mem_rsp_data),
    .lvl           (lvl_q),
    .mode          (mode_q),
    .is_leaf       (d_leaf),
    .is_fault      (d_fault),
    .present       (d_present),
    .bad_frag      (d_bad),
    .uncached_next (d_unc),
    .log2sz        (d_log2)
  );

  pt_result_calc u_res (
    .entry  (mem_rsp_data),
    .log2sz (d_log2),
    .vpn    (vpn_q),
    .paddr  (r_paddr),
    .vbase  (r_vbase)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      lvl_q         <= LV_DIR2;
      vpn_q         <= '0;
      mode_q        <= '0;
      addr_q        <= '0;
      unc_q         <= 1'b0;
      done_valid    <= 1'b0;
      done_entry    <= '0;
      done_log2size <= '0;
      done_paddr    <= '0;
      done_vbase    <= '0;
      fault_valid   <= 1'b0;
      fault_present <= 1'b0;
      fault_mode    <= '0;
      cfg_err       <= 1'b0;
    end else begin
      done_valid  <= 1'b0;
      fault_valid <= 1'b0;
      cfg_err     <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          vpn_q  <= req_vpn;
          mode_q <= req_mode;
          lvl_q  <= LV_DIR2;
          addr_q <= table_addr({{(ENT_W-PA_W){1'b0}}, req_base},
                               level_index(req_vpn, LV_DIR2));
          unc_q  <= 1'b0;
          st_q   <= ST_ISSUE;
        end
        ST_ISSUE: if (mem_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          cfg_err <= d_bad;
          if (d_fault) begin
            fault_valid   <= 1'b1;
            fault_present <= d_present;
            fault_mode    <= mode_q;
            st_q          <= ST_IDLE;
          end else if (d_leaf) begin
            done_valid    <= 1'b1;
            done_entry    <= mem_rsp_data;
            done_log2size <= d_log2;
            done_paddr    <= r_paddr;
            done_vbase    <= r_vbase;
            st_q          <= ST_IDLE;
          end else begin
            lvl_q  <= lvl_nxt;
            addr_q <= table_addr(mem_rsp_data, level_index(vpn_q, lvl_nxt));
            unc_q  <= d_unc;
            st_q   <= ST_ISSUE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_uncached)); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    walk_waiting |-> !mem_req_valid); // R9
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_valid && fault_valid)); // R10
  AST_IDLE_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    walk_end |=> req_ready && (done_valid || fault_valid)); // R10
  AST_FIRST_CACHED: assert property (@(posedge clk) disable iff (!rst_n)
    walk_accept |=> mem_req_valid && !mem_req_uncached); // R1
  AST_LEAF_LEVEL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_taken && (lvl_q == LV_LEAF) |=> !mem_req_valid && req_ready); // R4
  AST_ERR_ONLY_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(rsp_taken) && $past(lvl_q) != LV_LEAF); // R8
endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_base = '0;
  logic [35:0] req_vpn = '0;
  logic [1:0]  req_mode = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [47:0] mem_req_addr;
  logic        mem_req_uncached;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done_valid;
  logic [63:0] done_entry;
  logic [5:0]  done_log2size;
  logic [47:0] done_paddr;
  logic [47:0] done_vbase;
  logic        fault_valid;
  logic        fault_present;
  logic [1:0]  fault_mode;
  logic        cfg_err;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_base(req_base),
    .req_vpn(req_vpn), .req_mode(req_mode),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_uncached(mem_req_uncached),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_entry(done_entry), .done_log2size(done_log2size),
    .done_paddr(done_paddr), .done_vbase(done_vbase),
    .fault_valid(fault_valid), .fault_present(fault_present), .fault_mode(fault_mode),
    .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(bit v, bit c, bit x, bit p,
                                     logic [4:0] frag, logic [4:0] bfs);
    logic [63:0] r;
    r = {$urandom, $urandom};
    r[0] = v; r[2] = c; r[4] = x; r[54] = p;
    r[11:7] = frag; r[63:59] = bfs;
    return r;
  endfunction

  task automatic run_walk(input logic [47:0] base, input logic [35:0] vpn,
                          input logic [1:0] mode, input logic [63:0] e0,
                          input logic [63:0] e1, input logic [63:0] e2,
                          input logic [63:0] e3, input int stall);
    logic [63:0] ents [4];
    logic [47:0] ea;
    logic        eu;
    bit          fin;
    ents = '{e0, e1, e2, e3};
    ea  = {base[47:6], 6'b0} + {36'b0, vpn[35:27], 3'b0};
    eu  = 1'b0;
    fin = 0;
    @(negedge clk);
    req_valid = 1'b1; req_base = base; req_vpn = vpn; req_mode = mode;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "busy ready", 64'(req_ready), 64'd0);
    for (int lv = 0; lv < 4 && !fin; lv++) begin
      logic [63:0] e;
      bit          flt, leaf, bad;
      int          span, l2;
      logic [63:0] msk, va, pa;
      for (int w = 0; w < 20 && !mem_req_valid; w++) @(negedge clk);
      chk(mem_req_valid == 1'b1, "R9", "req valid", 64'(mem_req_valid), 64'd1);
      chk(mem_req_addr == ea, lv == 0 ? "R1" : "R2", "addr", 64'(mem_req_addr), 64'(ea));
      chk(mem_req_uncached == eu, "R3", "uncached", 64'(mem_req_uncached), 64'(eu));
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(mem_req_valid && mem_req_addr == ea && mem_req_uncached == eu, "R9",
            "hold under stall", 64'(mem_req_addr), 64'(ea));
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(mem_req_valid == 1'b0, "R9", "no second request", 64'(mem_req_valid), 64'd0);
      e = ents[lv];
      mem_rsp_valid = 1'b1; mem_rsp_data = e;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      flt  = !e[0] || (e[4] && mode == 2'b10);
      leaf = (lv == 3) || e[54];
      bad  = (lv < 3) && (e[63:59] != 0);
      chk(cfg_err == bad, "R8", "cfg_err", 64'(cfg_err), 64'(bad));
      if (flt) begin
        chk(fault_valid && !done_valid, e[0] ? "R7" : "R6", "fault pulse",
            64'({fault_valid, done_valid}), 64'b10);
        chk(fault_present == e[0], "R6", "present", 64'(fault_present), 64'(e[0]));
        chk(fault_mode == mode, "R6", "mode", 64'(fault_mode), 64'(mode));
        fin = 1;
      end else if (leaf) begin
        span = 9 * (3 - lv);
        l2   = 12 + ((int'(e[11:7]) < span) ? int'(e[11:7]) : span);
        msk  = (64'd1 << l2) - 64'd1;
        va   = {16'b0, vpn, 12'b0};
        pa   = (({12'b0, e[51:12], 12'b0}) + (va & msk)) & 64'hFFFF_FFFF_FFFF;
        chk(done_valid && !fault_valid, e[4] ? "R7" : "R4", "done pulse",
            64'({done_valid, fault_valid}), 64'b10);
        chk(done_log2size == l2[5:0], "R4", "log2size", 64'(done_log2size), 64'(l2));
        chk(done_entry == e, "R5", "entry", done_entry, e);
        chk(done_paddr == pa[47:0], "R5", "paddr", 64'(done_paddr), pa);
        chk(done_vbase == (va[47:0] & ~msk[47:0]), "R5", "vbase",
            64'(done_vbase), 64'(va[47:0] & ~msk[47:0]));
        fin = 1;
      end else begin
        logic [35:0] sh;
        chk(!done_valid && !fault_valid, "R2", "walk continues",
            64'({done_valid, fault_valid}), 64'b00);
        sh = vpn >> (9 * (2 - lv));
        ea = {e[47:6], 6'b0} + {36'b0, sh[8:0], 3'b0};
        eu = !e[2];
      end
    end
    chk(req_ready == 1'b1, "R10", "idle after result", 64'(req_ready), 64'd1);
    @(negedge clk);
    chk(!done_valid && !fault_valid, "R10", "single-cycle pulse",
        64'({done_valid, fault_valid}), 64'b00);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && !mem_req_valid && !done_valid && !fault_valid && !cfg_err,
        "R11", "reset outputs",
        64'({req_ready, mem_req_valid, done_valid, fault_valid, cfg_err}), 64'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    // Full four-level walk
    run_walk(48'h1234_5678_9AC0, 36'h9_8765_4321, 2'b00,
             mk(1,1,0,0,0,0), mk(1,1,0,0,0,0), mk(1,1,0,0,0,0), mk(1,1,0,0,3,0), 0);
    // Top-level leaf, fragment clamped to 27 (R4)
    run_walk(48'h0000_0010_0000, 36'hF_FFFF_FFFF, 2'b01,
             mk(1,1,0,1,31,0), 0, 0, 0, 1);
    // Middle-level leaf, small fragment
    run_walk(48'hABCD_0000_0040, 36'h1_2345_6789, 2'b00,
             mk(1,1,0,0,0,0), mk(1,1,0,1,5,0), 0, 0, 0);
    // Lowest directory leaf, clamped to 9
    run_walk(48'h0, 36'h0_0ABC_DEF1, 2'b00,
             mk(1,0,0,0,0,0), mk(1,0,0,0,0,0), mk(1,1,0,1,20,0), 0, 2);
    // Invalid last-level entry (R6)
    run_walk(48'h5555_5555_5540, 36'h3_3333_3333, 2'b01,
             mk(1,1,0,0,0,0), mk(1,1,0,0,0,0), mk(1,1,0,0,0,0), mk(0,1,0,0,0,0), 0);
    // No-execute at middle level on execute access (R7)
    run_walk(48'h7000_0000_0000, 36'h0_1111_1111, 2'b10,
             mk(1,1,0,0,0,0), mk(1,1,1,0,0,0), 0, 0, 0);
    // No-execute bit with read access has no effect (R7)
    run_walk(48'h7000_0000_0000, 36'h0_1111_1111, 2'b00,
             mk(1,1,1,0,0,0), mk(1,1,1,0,0,0), mk(1,1,1,0,0,0), mk(1,1,1,0,0,0), 0);
    // Illegal block-fragment field in a directory entry, uncached next, stalls (R8, R3, R9)
    run_walk(48'h0123_4567_89C0, 36'hA_AAAA_AAAA, 2'b00,
             mk(1,0,0,0,0,5'h1F), mk(1,1,0,0,0,0), mk(1,0,0,0,0,5'h01), mk(1,1,0,0,0,0), 3);
    // Block-fragment bits at the last level are ignored (R8)
    run_walk(48'h0, 36'h0_0000_0001, 2'b00,
             mk(1,1,0,0,0,0), mk(1,1,0,0,0,0), mk(1,1,0,0,0,0), mk(1,1,0,0,0,5'h1F), 0);
    // Random walks
    for (int i = 0; i < 60; i++) begin
      logic [63:0] es [4];
      for (int k = 0; k < 4; k++)
        es[k] = mk(($urandom % 16) != 0, $urandom % 2, ($urandom % 4) == 0,
                   ($urandom % 4) == 0, 5'($urandom),
                   (($urandom % 8) == 0) ? 5'($urandom) : 5'd0);
      run_walk({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom % 3),
               es[0], es[1], es[2], es[3], int'($urandom % 3));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule